// File: doc/BRIEF.md
# Shift-and-Reduce Modular Checksum Engine

This block computes a check value over a stream of data words with a single running sum. For each accepted word it forms the value `(sum << S) + word` and reduces it modulo a fixed odd modulus `M`. Here `S` is the width of the running sum. The reduction runs on every word, so each word's contribution depends on where it sits in the message. The dividend register is `2*S` bits wide. A restoring remainder unit performs each reduction and retires one dividend bit per clock. After the last word, the engine runs one more shift-and-reduce step with a zero word, so the final word is also mixed in. The remainder of that step is the check value.

Words arrive through a valid/ready handshake with start-of-message and end-of-message flags. A start-of-message word loads the running sum from a seed parameter. A parameter selects an optional parity mode. In that mode the sum is `K-1` bits wide with a `(K-1)`-bit modulus, and the least significant bit of the check value holds the parity of every data bit in the message. In both modes the data word is `S` bits wide.

The control is a three-state machine:
- `ST_IDLE`: ready is high and a word may be accepted. Accepting a word moves the machine to `ST_WORD`.
- `ST_WORD`: the word's reduction runs. When it finishes on a middle word, the machine returns to `ST_IDLE`. When it finishes on the last word, the machine moves to `ST_TAIL`.
- `ST_TAIL`: the zero-word step runs. When it finishes, the machine publishes the check value with a done pulse and returns to `ST_IDLE`.

Top module: `cksum_shift_mod`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `chk_done` is 0 and `chk_value` is 0.
- R2: For words w0..wn-1, the check value is `t = ((s << S) + 0) mod M`, where `s` is the sum after the last word and each word applies `s = ((s << S) + wi) mod M`. The reported sum field is always below `M`. Without parity, `S = K` and `chk_value = t`.
- R3: A word accepted with `in_sof` = 1 starts from the `SEED` value rather than the previous sum.
- R4: After a word is accepted, `in_ready` stays low for exactly `2S+1` cycles when `in_eof` = 0, and for exactly `4S+2` cycles when `in_eof` = 1.
- R5: `chk_done` is a one-cycle pulse. It appears in the first cycle in which `in_ready` is high again after an end-of-message word.
- R6: In parity mode, `S = K-1`, `chk_value[K-1:1]` holds the sum, and `chk_value[0]` is the XOR of all data bits accepted since the start-of-message word.
- R7: `chk_value` keeps its value between done pulses. While `in_valid` is 0, data and flag inputs have no effect.
- R8: A message of one word, with `in_sof` and `in_eof` both set, produces the R2 value for that word.
- R9: A start-of-message word in the middle of a message discards the earlier words and clears the parity.
- R10: Flipping any single data bit, or any two bits of one word, changes the check value. In parity mode, flipping any three data bits also changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Engine can accept a word |
| in_data | input | K-PARITY_EN | Data word |
| in_sof | input | 1 | Word begins a message |
| in_eof | input | 1 | Word ends a message |
| chk_value | output | K | Latest check value |
| chk_done | output | 1 | One-cycle pulse when `chk_value` is updated |

## Verification
The hardest case to reach is a start-of-message word arriving while an earlier message is still unfinished. The normal framing never produces this, because every message ends with an end-of-message word. The bench drives broken framing on purpose: it sends a few words, then issues a fresh start-of-message word partway through, and expects only the later words to count, with the parity restarted. Error-detection behaviour is reached by replaying random messages with one, two or three data bits flipped and comparing the two check values.

// File: rtl/cksum_pkg.sv
package cksum_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WORD = 2'd1,
        ST_TAIL = 2'd2
    } cksum_state_e;
endpackage

// File: rtl/cksum_mod_reducer.sv
module cksum_mod_reducer #(
    parameter int IN_W = 32,
    parameter int M_W  = 16,
    parameter logic [M_W-1:0] M_VAL = 16'hFFF1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [IN_W-1:0] dividend,
    output logic            busy,
    output logic            done,
    output logic [M_W-1:0]  rem
);
    localparam int CNT_W = $clog2(IN_W + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(IN_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [IN_W-1:0]  shreg;
    logic [M_W-1:0]   acc;
    logic [CNT_W-1:0] cnt;
    logic             done_q;
    logic [M_W:0]     trial;
    logic [M_W:0]     diff;
    logic             ge;
    logic [M_W-1:0]   acc_nxt;

    always_comb begin
        trial   = {acc, shreg[IN_W-1]};
        diff    = trial - {1'b0, M_VAL};
        ge      = (trial >= {1'b0, M_VAL});
        acc_nxt = ge ? diff[M_W-1:0] : trial[M_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            acc    <= '0;
            cnt    <= '0;
            done_q <= 1'b0;
        end else if (start) begin
            shreg  <= dividend;
            acc    <= '0;
            cnt    <= CNT_LOAD;
            done_q <= 1'b0;
        end else if (cnt != '0) begin
            acc    <= acc_nxt;
            shreg  <= shreg << 1;
            cnt    <= cnt - CNT_ONE;
            done_q <= (cnt == CNT_ONE);
        end else begin
            done_q <= 1'b0;
        end
    end

    assign busy = (cnt != '0);
    assign done = done_q;
    assign rem  = acc;

    // R2
    rem_below_mod_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (rem < M_VAL));
    // R4
    start_when_free_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/cksum_parity_acc.sv
module cksum_parity_acc #(
    parameter int DW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          restart,
    input  logic [DW-1:0] data,
    output logic          par
);
    logic par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q <= 1'b0;
        end else if (load) begin
            par_q <= (restart ? 1'b0 : par_q) ^ (^data);
        end
    end

    assign par = par_q;
endmodule

// File: rtl/cksum_shift_mod.sv
module cksum_shift_mod #(
    parameter int K = 16,
    parameter int PARITY_EN = 0,
    parameter logic [K-1:0] MOD_VAL = 16'hFFF1,
    parameter logic [K-1:0] SEED = '0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [K-PARITY_EN-1:0] in_data,
    input  logic                   in_sof,
    input  logic                   in_eof,
    output logic [K-1:0]           chk_value,
    output logic                   chk_done
);
    import cksum_pkg::*;

    localparam int S_W    = K - PARITY_EN;
    localparam int SUM2_W = 2 * S_W;
    localparam logic [S_W-1:0] MOD_S  = MOD_VAL[S_W-1:0];
    localparam logic [S_W-1:0] SEED_S = SEED[S_W-1:0];

    cksum_state_e      state, state_nxt;
    logic [S_W-1:0]    sum_q;
    logic              last_q;
    logic              accept;
    logic [S_W-1:0]    base;
    logic              red_start;
    logic [SUM2_W-1:0] red_div;
    logic              red_busy;
    logic              red_done;
    logic [S_W-1:0]    red_rem;
    logic [K-1:0]      chk_nxt;

    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign base     = in_sof ? SEED_S : sum_q;

    always_comb begin
        red_start = 1'b0;
        red_div   = '0;
        unique case (state)
            ST_IDLE: begin
                red_start = accept;
                red_div   = {base, in_data};
            end
            ST_WORD: begin
                red_start = red_done && last_q;
                red_div   = {red_rem, {S_W{1'b0}}};
            end
            ST_TAIL: begin
                red_start = 1'b0;
            end
            default: begin
                red_start = 1'b0;
            end
        endcase
    end

    cksum_mod_reducer #(
        .IN_W (SUM2_W),
        .M_W  (S_W),
        .M_VAL(MOD_S)
    ) reducer_i (
        .clk     (clk),
        .rst     (rst),
        .start   (red_start),
        .dividend(red_div),
        .busy    (red_busy),
        .done    (red_done),
        .rem     (red_rem)
    );

    generate
        if (PARITY_EN != 0) begin : g_par
            logic par_bit;
            cksum_parity_acc #(.DW(S_W)) parity_i (
                .clk    (clk),
                .rst    (rst),
                .load   (accept),
                .restart(in_sof),
                .data   (in_data),
                .par    (par_bit)
            );
            assign chk_nxt = {red_rem, par_bit};
        end else begin : g_plain
            assign chk_nxt = red_rem;
        end
    endgenerate

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (accept)               state_nxt = ST_WORD;
            ST_WORD: if (red_done && last_q)   state_nxt = ST_TAIL;
                     else if (red_done)        state_nxt = ST_IDLE;
            ST_TAIL: if (red_done)             state_nxt = ST_IDLE;
            default:                           state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q     <= '0;
            last_q    <= 1'b0;
            chk_value <= '0;
            chk_done  <= 1'b0;
        end else begin
            chk_done <= 1'b0;
            unique case (state)
                ST_IDLE: if (accept) last_q <= in_eof;
                ST_WORD: if (red_done) sum_q <= red_rem;
                ST_TAIL: if (red_done) begin
                    sum_q     <= red_rem;
                    chk_value <= chk_nxt;
                    chk_done  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R4
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);
    // R4
    reducer_idle_chk: assert property (@(posedge clk) disable iff (rst)
        red_start |-> !red_busy);
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        chk_done |=> !chk_done);
    // R5
    done_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> in_ready);
    // R2
    sum_field_range_chk: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> (chk_value[K-1:PARITY_EN] < MOD_S));
    // R7
    value_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_done |-> $stable(chk_value));
endmodule

// File: tb/cksum_shift_mod_tb_top.sv
module cksum_shift_mod_tb_top;
    localparam logic [15:0] SEED1 = 16'd1234;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        v0 = 0, s0 = 0, e0 = 0, r0, dn0;
    logic [15:0] d0 = '0, c0;
    logic        v1 = 0, s1 = 0, e1 = 0, r1, dn1;
    logic [14:0] d1 = '0;
    logic [15:0] c1;

    cksum_shift_mod #(.K(16), .PARITY_EN(0), .MOD_VAL(16'd65521), .SEED(16'd0)) dut_i (
        .clk(clk), .rst(rst), .in_valid(v0), .in_ready(r0), .in_data(d0),
        .in_sof(s0), .in_eof(e0), .chk_value(c0), .chk_done(dn0));

    cksum_shift_mod #(.K(16), .PARITY_EN(1), .MOD_VAL(16'd32749), .SEED(SEED1)) dut_p_i (
        .clk(clk), .rst(rst), .in_valid(v1), .in_ready(r1), .in_data(d1),
        .in_sof(s1), .in_eof(e1), .chk_value(c1), .chk_done(dn1));

    int total = 0;
    int bad = 0;
    logic [15:0] words [0:15];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_chk(input bit par, input int first, input int n);
        longint unsigned m   = par ? 64'd32749 : 64'd65521;
        int              s   = par ? 15 : 16;
        longint unsigned acc = par ? longint'(SEED1[14:0]) : 64'd0;
        longint unsigned msk = par ? 64'h7FFF : 64'hFFFF;
        bit p = 1'b0;
        for (int i = first; i < n; i++) begin
            longint unsigned w = longint'(words[i]) & msk;
            acc = ((acc << s) + w) % m;
            p   = p ^ (^w[15:0]);
        end
        acc = (acc << s) % m;
        return par ? {acc[14:0], p} : acc[15:0];
    endfunction

    function automatic bit rdy(input bit par);
        return par ? r1 : r0;
    endfunction
    function automatic bit dne(input bit par);
        return par ? dn1 : dn0;
    endfunction
    function automatic logic [15:0] val(input bit par);
        return par ? c1 : c0;
    endfunction

    task automatic send_word(input bit par, input logic [15:0] d, input bit sof, input bit eof,
                             output int lowcnt);
        @(negedge clk);
        if (par) begin v1 = 1; d1 = d[14:0]; s1 = sof; e1 = eof; end
        else     begin v0 = 1; d0 = d;       s0 = sof; e0 = eof; end
        while (!rdy(par)) @(negedge clk);
        @(negedge clk);
        if (par) begin v1 = 0; d1 = 15'h5A5A; s1 = 1; e1 = 1; end
        else     begin v0 = 0; d0 = 16'hA5A5; s0 = 1; e0 = 1; end
        lowcnt = 0;
        while (!rdy(par)) begin
            lowcnt++;
            @(negedge clk);
        end
    endtask

    // Sends words[0..n-1]; a second sof at index restart (-1 for none).
    task automatic run_msg(input bit par, input int n, input int restart, output logic [15:0] res);
        int lc;
        int sw = par ? 15 : 16;
        int first = (restart > 0) ? restart : 0;
        logic [15:0] exp;
        res = '0;
        for (int i = 0; i < n; i++) begin
            bit last = (i == n - 1);
            send_word(par, words[i], (i == 0) || (i == restart), last, lc);
            if (!last) begin
                check(lc == 2 * sw + 1, "R4 mid-word ready low", lc, 2 * sw + 1);
                check(dne(par) == 0, "R5 no early done", dne(par), 0);
            end else begin
                check(lc == 4 * sw + 2, "R4 last-word ready low", lc, 4 * sw + 2);
                check(dne(par) == 1, "R5 done at ready return", dne(par), 1);
                res = val(par);
            end
        end
        @(negedge clk);
        check(dne(par) == 0, "R5 done one cycle", dne(par), 0);
        exp = model_chk(par, first, n);
        check(res == exp, par ? "R2 R3 R6 check value parity" : "R2 R3 check value", res, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] res, ref_v, hold_v;
        void'($urandom(32'd7741));
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check(r0 == 1 && r1 == 1, "R1 ready after reset", {r0, r1}, 2'b11);
        check(dn0 == 0 && dn1 == 0, "R1 done low after reset", {dn0, dn1}, 0);
        check(c0 == 0 && c1 == 0, "R1 value zero after reset", {c0, c1}, 0);

        for (int p = 0; p < 2; p++) begin
            // R8 single word, R2 directed patterns
            words[0] = 16'hFFFF;
            run_msg(p[0], 1, -1, res);
            for (int i = 0; i < 4; i++) words[i] = 16'h0000;
            run_msg(p[0], 4, -1, res);
            for (int i = 0; i < 4; i++) words[i] = 16'hFFFF;
            run_msg(p[0], 4, -1, res);
            words[0] = 16'h0001;
            run_msg(p[0], 1, -1, res);
            // random messages R2 R3 R6
            for (int t = 0; t < 15; t++) begin
                int n = 1 + int'($urandom_range(0, 7));
                for (int i = 0; i < n; i++) words[i] = 16'($urandom);
                run_msg(p[0], n, -1, res);
            end
            // R9 restart mid-message
            for (int i = 0; i < 6; i++) words[i] = 16'($urandom);
            run_msg(p[0], 6, 3, res);
            // R7 hold with idle inputs toggling
            hold_v = val(p[0]);
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (p == 1) begin d1 = 15'($urandom); s1 = 1'($urandom); e1 = 1'($urandom); end
                else        begin d0 = 16'($urandom); s0 = 1'($urandom); e0 = 1'($urandom); end
                check(val(p[0]) == hold_v && rdy(p[0]) && !dne(p[0]), "R7 hold while idle",
                      val(p[0]), hold_v);
            end
            // R10 error detection
            for (int t = 0; t < 4; t++) begin
                int wi, b1, b2;
                int sw = (p == 1) ? 15 : 16;
                for (int i = 0; i < 4; i++) words[i] = 16'($urandom);
                run_msg(p[0], 4, -1, ref_v);
                wi = int'($urandom_range(0, 3));
                b1 = int'($urandom_range(0, sw - 1));
                words[wi][b1] = ~words[wi][b1];
                run_msg(p[0], 4, -1, res);
                check(res != ref_v, "R10 single flip detected", res, ref_v);
                b2 = (b1 + 1 + int'($urandom_range(0, sw - 2))) % sw;
                words[wi][b1] = ~words[wi][b1];
                words[wi][b1] = ~words[wi][b1];
                words[wi][b2] = ~words[wi][b2];
                run_msg(p[0], 4, -1, res);
                check(res != ref_v, "R10 double flip detected", res, ref_v);
                if (p == 1) begin
                    words[(wi + 1) % 4][3] = ~words[(wi + 1) % 4][3];
                    run_msg(1'b1, 4, -1, res);
                    check(res != ref_v, "R10 triple flip detected R6", res, ref_v);
                end
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule